// File: doc/BRIEF.md
# Sector-Erase Command Decoder for a Serial Flash Port

This block is the serial receive front end of an on-chip user flash array. It watches a four-wire serial slave port (clock, active-low select, data in, data out) and recognises one command: sector erase, opcode 0x20. When a complete, correctly framed erase command has arrived, it hands the flash controller a single erase request together with the number of the sector to erase. Reads, writes, status polling and the erase itself belong to other blocks.

A mode input chooses between two framings. In the short framing the command is just the 8-bit opcode, and sector 0 is always erased. In the long framing the opcode is followed immediately by a 16-bit address, and the sector comes from the top address bit(s). All serial inputs and the mode input pass through a synchroniser into the system clock domain, where the whole decoder runs. The request is committed only when the select line returns high. It is withheld when the flash controller reports busy.

The data-out line is never driven, because the command returns no data. It is presented as a data/enable pair so the pad ring can build the tri-state buffer.

Top module: `spi_erase_decoder`

## Requirements
- R1: With `ext_mode` low, a frame of exactly 8 bits equal to 0x20, received most significant bit first and sampled on rising `spi_sck`, produces one request with `erase_sector` = 0.
- R2: With `ext_mode` high, a frame of exactly 24 bits (0x20 followed by a 16-bit address, MSB first) produces one request whose `erase_sector` equals address bit 15.
- R3: A request is issued only after `spi_cs_n` returns high. No request appears while select is still low, even after the last bit has arrived.
- R4: A frame whose bit count differs from the count for the current mode (8 in short mode, 24 in long mode) produces no request.
- R5: A correctly sized frame whose first 8 bits are not 0x20 produces no request.
- R6: If `flash_busy` is high when a valid frame completes, the frame is dropped. No request is issued then, and none is issued later when busy clears.
- R7: `erase_req` is high for exactly one system clock cycle per accepted frame.
- R8: `miso_oe` stays low and `miso_out` stays 0 at all times.
- R9: While `rst_n` is low, and directly after reset, `erase_req` is 0 and `erase_sector` is 0.
- R10: The bit counter and shift register are cleared while `spi_cs_n` is high, so `spi_sck` edges outside a frame have no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, asynchronous to `clk` |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| ext_mode | input | 1 | 0: opcode-only framing; 1: opcode plus 16-bit address |
| flash_busy | input | 1 | Flash controller cannot take a request |
| erase_req | output | 1 | One-cycle erase request |
| erase_sector | output | SECTOR_BITS | Sector to erase, held until the next request |
| miso_out | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the data-out pad |

## Verification
The bench uses the default parameters: an 8-bit opcode of 0x20, a 16-bit address, a one-bit sector field and two synchroniser stages. This puts every frame length the requirements name within reach of short runs: 7, 8, 9, 23, 24 and 25 bits, with both values of the sector bit. Because the frame is 24 bits, the saturating overrun path runs at its real boundary. One-bit sectors keep the sector value distinct in both framings.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    // Receive state of the frame tracker
    typedef enum logic [1:0] {
        FRM_IDLE = 2'd0,   // select high, nothing received
        FRM_RECV = 2'd1,   // inside a frame, count still meaningful
        FRM_OVER = 2'd2    // more bits than the longest legal frame
    } frm_state_e;

    // Bit positions inside the synchronised input bundle
    localparam int SIG_MODE = 0;
    localparam int SIG_MOSI = 1;
    localparam int SIG_CS_N = 2;
    localparam int SIG_SCK  = 3;
    localparam int SIG_NUM  = 4;

    // Reset image of the bundle: select inactive (high), all else low
    localparam logic [SIG_NUM-1:0] SIG_IDLE = 4'b0100;

endpackage

// File: rtl/spi_erase_sync.sv
module spi_erase_sync #(
    parameter int                WIDTH     = 4,
    parameter int                STAGES    = 2,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RESET_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= chain_d[s];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/spi_erase_frame.sv
module spi_erase_frame
    import spi_erase_pkg::*;
#(
    parameter int                 OPCODE_W    = 8,
    parameter int                 ADDR_W      = 16,
    parameter int                 SECTOR_BITS = 1,
    parameter logic [OPCODE_W-1:0] OPCODE     = 8'h20,
    localparam int                FRAME_W     = OPCODE_W + ADDR_W,
    localparam int                CNT_W       = $clog2(FRAME_W + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sck_s,
    input  logic                   cs_n_s,
    input  logic                   mosi_s,
    input  logic                   ext_s,
    output logic                   cmd_valid,
    output logic [SECTOR_BITS-1:0] cmd_sector,
    output logic [CNT_W-1:0]       bit_cnt
);

    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(OPCODE_W);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);

    typedef struct packed {
        logic                   sck_prev;
        logic                   cs_prev;
        frm_state_e             state;
        logic [CNT_W-1:0]       cnt;
        logic [FRAME_W-1:0]     shreg;
        logic                   valid;
        logic [SECTOR_BITS-1:0] sector;
    } frame_t;

    frame_t frm_d, frm_q;

    logic                   sck_rise;
    logic                   cs_rise;
    logic                   short_ok;
    logic                   long_ok;
    logic [OPCODE_W-1:0]    short_op;
    logic [OPCODE_W-1:0]    long_op;
    logic [SECTOR_BITS-1:0] long_sector;

    always_comb begin
        sck_rise    = sck_s & ~frm_q.sck_prev;
        cs_rise     = cs_n_s & ~frm_q.cs_prev;
        short_op    = frm_q.shreg[OPCODE_W-1:0];
        long_op     = frm_q.shreg[FRAME_W-1 -: OPCODE_W];
        long_sector = frm_q.shreg[ADDR_W-1 -: SECTOR_BITS];
        short_ok    = !ext_s && (frm_q.state == FRM_RECV)
                      && (frm_q.cnt == LEN_SHORT) && (short_op == OPCODE);
        long_ok     = ext_s && (frm_q.state == FRM_RECV)
                      && (frm_q.cnt == LEN_LONG) && (long_op == OPCODE);

        frm_d          = frm_q;
        frm_d.sck_prev = sck_s;
        frm_d.cs_prev  = cs_n_s;
        frm_d.valid    = 1'b0;

        if (cs_n_s) begin
            // frame closes on the select rising edge; judge it once
            if (cs_rise && (short_ok || long_ok)) begin
                frm_d.valid  = 1'b1;
                frm_d.sector = long_ok ? long_sector : '0;
            end
            frm_d.state = FRM_IDLE;
            frm_d.cnt   = '0;
            frm_d.shreg = '0;
        end else if (sck_rise && (frm_q.state != FRM_OVER)) begin
            frm_d.shreg = {frm_q.shreg[FRAME_W-2:0], mosi_s};
            if (frm_q.cnt == LEN_LONG) begin
                frm_d.state = FRM_OVER;
            end else begin
                frm_d.state = FRM_RECV;
                frm_d.cnt   = frm_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q.sck_prev <= 1'b0;
            frm_q.cs_prev  <= 1'b1;
            frm_q.state    <= FRM_IDLE;
            frm_q.cnt      <= '0;
            frm_q.shreg    <= '0;
            frm_q.valid    <= 1'b0;
            frm_q.sector   <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign cmd_valid  = frm_q.valid;
    assign cmd_sector = frm_q.sector;
    assign bit_cnt    = frm_q.cnt;

endmodule

// File: rtl/spi_erase_issue.sv
module spi_erase_issue #(
    parameter int SECTOR_BITS = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [SECTOR_BITS-1:0] cmd_sector,
    input  logic                   flash_busy,
    output logic                   erase_req,
    output logic [SECTOR_BITS-1:0] erase_sector
);

    typedef struct packed {
        logic                   req;
        logic [SECTOR_BITS-1:0] sector;
    } issue_t;

    issue_t iss_d, iss_q;

    always_comb begin
        iss_d     = iss_q;
        iss_d.req = cmd_valid && !flash_busy;
        if (iss_d.req) begin
            iss_d.sector = cmd_sector;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_q.req    <= 1'b0;
            iss_q.sector <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign erase_req    = iss_q.req;
    assign erase_sector = iss_q.sector;

endmodule

// File: rtl/spi_erase_decoder.sv
module spi_erase_decoder
    import spi_erase_pkg::*;
#(
    parameter int                  OPCODE_W    = 8,
    parameter int                  ADDR_W      = 16,
    parameter int                  SECTOR_BITS = 1,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [OPCODE_W-1:0] OPCODE      = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sck,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    input  logic                   ext_mode,
    input  logic                   flash_busy,
    output logic                   erase_req,
    output logic [SECTOR_BITS-1:0] erase_sector,
    output logic                   miso_out,
    output logic                   miso_oe
);

    localparam int FRAME_W = OPCODE_W + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    logic [SIG_NUM-1:0]     raw_bus;
    logic [SIG_NUM-1:0]     sync_bus;
    logic                   sync_cs_n;
    logic                   cmd_valid;
    logic [SECTOR_BITS-1:0] cmd_sector;
    logic [CNT_W-1:0]       bit_cnt;

    always_comb begin
        raw_bus           = '0;
        raw_bus[SIG_SCK]  = spi_sck;
        raw_bus[SIG_CS_N] = spi_cs_n;
        raw_bus[SIG_MOSI] = spi_mosi;
        raw_bus[SIG_MODE] = ext_mode;
    end

    spi_erase_sync #(
        .WIDTH    (SIG_NUM),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(SIG_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_bus),
        .sync_out(sync_bus)
    );

    assign sync_cs_n = sync_bus[SIG_CS_N];

    spi_erase_frame #(
        .OPCODE_W   (OPCODE_W),
        .ADDR_W     (ADDR_W),
        .SECTOR_BITS(SECTOR_BITS),
        .OPCODE     (OPCODE)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sync_bus[SIG_SCK]),
        .cs_n_s    (sync_cs_n),
        .mosi_s    (sync_bus[SIG_MOSI]),
        .ext_s     (sync_bus[SIG_MODE]),
        .cmd_valid (cmd_valid),
        .cmd_sector(cmd_sector),
        .bit_cnt   (bit_cnt)
    );

    spi_erase_issue #(
        .SECTOR_BITS(SECTOR_BITS)
    ) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_sector  (cmd_sector),
        .flash_busy  (flash_busy),
        .erase_req   (erase_req),
        .erase_sector(erase_sector)
    );

    // erase returns no data: the output pad is never enabled
    assign miso_out = 1'b0;
    assign miso_oe  = 1'b0;

endmodule

// File: rtl/spi_erase_checker.sv
module spi_erase_checker #(
    parameter int SECTOR_BITS = 1,
    parameter int CNT_W       = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [SECTOR_BITS-1:0] cmd_sector,
    input logic                   flash_busy,
    input logic                   erase_req,
    input logic [SECTOR_BITS-1:0] erase_sector,
    input logic                   sync_cs_n,
    input logic [CNT_W-1:0]       bit_cnt
);

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req); // R7

    AST_BUSY_DROPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && flash_busy) |=> !erase_req); // R6

    AST_REQ_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(cmd_valid && !flash_busy)); // R3

    AST_SECTOR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !flash_busy) |=> (erase_req && erase_sector == $past(cmd_sector))); // R2

    AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        sync_cs_n |=> (bit_cnt == '0)); // R10

endmodule

bind spi_erase_decoder spi_erase_checker #(
    .SECTOR_BITS(SECTOR_BITS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_sector  (cmd_sector),
    .flash_busy  (flash_busy),
    .erase_req   (erase_req),
    .erase_sector(erase_sector),
    .sync_cs_n   (sync_cs_n),
    .bit_cnt     (bit_cnt)
);

// File: tb/spi_erase_decoder_bench.sv
module spi_erase_decoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic ext_mode = 1'b0;
    logic flash_busy = 1'b0;
    logic erase_req;
    logic [0:0] erase_sector;
    logic miso_out;
    logic miso_oe;

    always #2 clk = ~clk; // 250 MHz

    spi_erase_decoder u_spi_erase_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .ext_mode    (ext_mode),
        .flash_busy  (flash_busy),
        .erase_req   (erase_req),
        .erase_sector(erase_sector),
        .miso_out    (miso_out),
        .miso_oe     (miso_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    int wide     = 0;
    int pad_on   = 0;
    logic last_sector = 1'b0;
    logic prev_req = 1'b0;
    bit   done = 1'b0;

    // output monitor, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (erase_req === 1'b1) begin
            pulses++;
            last_sector = erase_sector[0];
            if (prev_req) wide++;
        end
        if (miso_oe !== 1'b0 || miso_out !== 1'b0) pad_on++;
        prev_req = (erase_req === 1'b1);
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic spi_frame(input bit ext, input int nbits, input logic [31:0] word,
                             input string tag);
        int start;
        ext_mode = ext;
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = word[31-i];
            repeat (4) @(negedge clk);
            spi_sck = 1'b1;
            repeat (4) @(negedge clk);
            spi_sck = 1'b0;
        end
        start = pulses;
        repeat (12) @(negedge clk);
        chk(pulses == start, {tag, " R3 request before select release"}, pulses - start, 0);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0]  tag;
        logic        ext;
        logic [5:0]  nbits;
        logic [31:0] word;
        logic        busy;
        logic        hit;
        logic        sec;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0, 6'd8,  32'h2000_0000, 1'b0, 1'b1, 1'b0}, // R1 short frame
        '{4'd2, 1'b1, 6'd24, 32'h2080_0000, 1'b0, 1'b1, 1'b1}, // R2 sector 1
        '{4'd2, 1'b1, 6'd24, 32'h207F_FF00, 1'b0, 1'b1, 1'b0}, // R2 sector 0
        '{4'd1, 1'b0, 6'd8,  32'h2000_0000, 1'b0, 1'b1, 1'b0}, // R1 back to sector 0
        '{4'd4, 1'b0, 6'd7,  32'h2000_0000, 1'b0, 1'b0, 1'b0}, // R4 short by one
        '{4'd4, 1'b0, 6'd9,  32'h2080_0000, 1'b0, 1'b0, 1'b0}, // R4 long by one
        '{4'd4, 1'b0, 6'd24, 32'h2080_0000, 1'b0, 1'b0, 1'b0}, // R4 long frame in short mode
        '{4'd4, 1'b1, 6'd8,  32'h2000_0000, 1'b0, 1'b0, 1'b0}, // R4 no address
        '{4'd4, 1'b1, 6'd23, 32'h2080_0000, 1'b0, 1'b0, 1'b0}, // R4 address short
        '{4'd4, 1'b1, 6'd25, 32'h2080_0000, 1'b0, 1'b0, 1'b0}, // R4 overrun
        '{4'd5, 1'b0, 6'd8,  32'h2100_0000, 1'b0, 1'b0, 1'b0}, // R5 wrong opcode
        '{4'd5, 1'b1, 6'd24, 32'hA080_0000, 1'b0, 1'b0, 1'b0}, // R5 wrong opcode long
        '{4'd6, 1'b0, 6'd8,  32'h2000_0000, 1'b1, 1'b0, 1'b0}, // R6 busy short
        '{4'd6, 1'b1, 6'd24, 32'h20FF_FF00, 1'b1, 1'b0, 1'b0}, // R6 busy long
        '{4'd2, 1'b1, 6'd24, 32'h20FF_FF00, 1'b0, 1'b1, 1'b1}  // R2 after busy clears
    };

    initial begin
        // R9: reset state
        repeat (5) @(negedge clk);
        chk(erase_req == 1'b0, "R9 erase_req in reset", int'(erase_req), 0);
        chk(erase_sector == 1'b0, "R9 erase_sector in reset", int'(erase_sector), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(erase_req == 1'b0 && pulses == 0, "R9 no request after reset", pulses, 0);

        foreach (VECS[k]) begin
            int start;
            start = pulses;
            flash_busy = VECS[k].busy;
            spi_frame(VECS[k].ext, int'(VECS[k].nbits), VECS[k].word,
                      $sformatf("R%0d vec%0d", VECS[k].tag, k));
            flash_busy = 1'b0;
            repeat (12) @(negedge clk);
            chk((pulses - start) == int'(VECS[k].hit),
                $sformatf("R%0d vec%0d request count", VECS[k].tag, k),
                pulses - start, int'(VECS[k].hit));
            if (VECS[k].hit) begin
                chk(last_sector == VECS[k].sec,
                    $sformatf("R%0d vec%0d sector", VECS[k].tag, k),
                    int'(last_sector), int'(VECS[k].sec));
            end
        end

        // R10: clock edges with select high, then a clean short frame
        begin
            int start;
            start = pulses;
            spi_mosi = 1'b1;
            for (int i = 0; i < 5; i++) begin
                repeat (4) @(negedge clk);
                spi_sck = 1'b1;
                repeat (4) @(negedge clk);
                spi_sck = 1'b0;
            end
            repeat (8) @(negedge clk);
            chk(pulses == start, "R10 idle clocks raise no request", pulses - start, 0);
            spi_frame(1'b0, 8, 32'h2000_0000, "R10 frame");
            chk(pulses - start == 1, "R10 frame after idle clocks", pulses - start, 1);
            chk(last_sector == 1'b0, "R10 sector", int'(last_sector), 0);
        end

        // R1 with R6: busy raised only after the frame has closed does not drop it
        begin
            int start;
            start = pulses;
            spi_frame(1'b0, 8, 32'h2000_0000, "R1 late busy");
            flash_busy = 1'b1;
            repeat (8) @(negedge clk);
            flash_busy = 1'b0;
            chk(pulses - start == 1, "R1 request before busy", pulses - start, 1);
        end

        chk(wide == 0, "R7 request wider than one cycle", wide, 0);
        chk(pad_on == 0, "R8 data-out pad enabled or driven", pad_on, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule